// File: doc/BRIEF.md
# Machine Status Register with Write Legalization

This block holds the machine-level status word of a hart and makes every software write legal before it is stored. A write brings a full XLEN-wide value; only a fixed set of bit ranges is taken from it, unsupported previous-privilege codes are replaced, extension-state fields are forced according to the configuration straps, the 64-bit XLEN-control fields keep their old contents and the dirty summary at the top bit is recomputed from the stored state fields.

The straps say whether user mode and supervisor mode exist and whether floating-point values live in the integer registers. They are plain level inputs and may change between writes; each write is legalized against the straps present at its clock edge. Besides the stored word, the block drives a supervisor-level view that shows only the fields lower privilege software may see. A write is a single-cycle pulse on `wr_en` and takes effect on the next rising clock edge. There is no back-pressure: the register accepts a write on every cycle.

Field positions used throughout: SIE 1, SPIE 5, SPP 8, VS 10:9, MPP 12:11, FS 14:13, XS 16:15, MPRV 17, SUM 18, MXR 19, UXL 33:32, SXL 35:34, SD at XLEN-1. State encodings: 00 Off, 01 Initial, 10 Clean, 11 Dirty. Privilege encodings: 00 user, 01 supervisor, 11 machine, 10 reserved.

Top module: `mstatus_legal`

## Requirements
- R1: After reset the stored word has MPP = 11, the XLEN-control fields UXL and SXL both equal to the `RESET_XL` parameter (default 10) when XLEN is 64, and every other bit zero.
- R2: On a write, bits 22..7, 5..3 and 1..0 of the stored word come from the write data (subject to R3 to R5 and R7); bits 6 and 2 are stored as zero, and every bit above 22 other than SD, UXL and SXL is stored as zero.
- R3: A written MPP code naming an unimplemented level (10 always; 00 without user mode; 01 without supervisor mode) is replaced by the lowest implemented level: 00 with user mode, else 01 with supervisor mode, else 11.
- R4: The XS field (bits 16:15) is stored as 00 on every write, whatever was written.
- R5: With `cfg_fp_in_int` high, FS (bits 14:13) is stored as 00; with it low FS takes the written value.
- R6: SD (bit XLEN-1) of the stored word is 1 exactly when FS, XS or VS holds 11, and 0 otherwise.
- R7: MPRV (bit 17) is stored as 0 on a write while `cfg_user_en` is low.
- R8: With XLEN 64, UXL (33:32) and SXL (35:34) never change after reset, and bits 37:36 are always stored as zero.
- R9: The supervisor view equals the stored word on bits SIE, SPIE, SPP, VS, FS, XS, SUM, MXR, UXL and SD, and is zero on all other bits.
- R10: In a cycle without `wr_en` the stored word keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_data | input | XLEN | Raw value written by software |
| cfg_user_en | input | 1 | User mode implemented |
| cfg_super_en | input | 1 | Supervisor mode implemented |
| cfg_fp_in_int | input | 1 | Floating-point values held in integer registers |
| status_o | output | XLEN | Stored, legalized machine status word |
| sstatus_o | output | XLEN | Supervisor-visible restricted view |

## Verification
The assertions assume the straps are stable within a clock cycle and sampled at the same edge as the write, and that reset is applied before the first write. They make no assumption about the write data, so the stimulus drives fully random 64-bit words with random strap combinations (including supervisor without user) changed only between edges. Directed cases add the reserved MPP code under every strap setting, the all-ones word, dirty states reached only through VS, and idle cycles between writes.

// File: rtl/mstatus_pkg.sv
package mstatus_pkg;

  typedef enum logic [1:0] {
    EXT_OFF   = 2'b00,
    EXT_INIT  = 2'b01,
    EXT_CLEAN = 2'b10,
    EXT_DIRTY = 2'b11
  } ext_e;

  typedef enum logic [1:0] {
    PRV_U    = 2'b00,
    PRV_S    = 2'b01,
    PRV_RSVD = 2'b10,
    PRV_M    = 2'b11
  } prv_e;

  localparam int unsigned SIE_B   = 1;
  localparam int unsigned SPIE_B  = 5;
  localparam int unsigned SPP_B   = 8;
  localparam int unsigned VS_LO   = 9;
  localparam int unsigned MPP_LO  = 11;
  localparam int unsigned FS_LO   = 13;
  localparam int unsigned XS_LO   = 15;
  localparam int unsigned MPRV_B  = 17;
  localparam int unsigned SUM_B   = 18;
  localparam int unsigned MXR_B   = 19;
  localparam int unsigned UXL_LO  = 32;
  localparam int unsigned SXL_LO  = 34;
  localparam int unsigned WIDE_HI = 22;

  // A privilege code is legal when the hart implements that level.
  function automatic logic prv_ok(input logic [1:0] p, input logic user_en,
                                  input logic super_en);
    unique case (p)
      PRV_M:   prv_ok = 1'b1;
      PRV_S:   prv_ok = super_en;
      PRV_U:   prv_ok = user_en;
      default: prv_ok = 1'b0;
    endcase
  endfunction

  function automatic logic [1:0] prv_lowest(input logic user_en, input logic super_en);
    if (user_en)       prv_lowest = PRV_U;
    else if (super_en) prv_lowest = PRV_S;
    else               prv_lowest = PRV_M;
  endfunction

  // Bits taken from the raw write (before fixups).
  function automatic logic bit_from_write(input int unsigned i);
    bit_from_write = (i <= WIDE_HI) && (i != 6) && (i != 2);
  endfunction

  // Bits shown in the supervisor view, apart from SD.
  function automatic logic bit_in_sview(input int unsigned i, input int unsigned xlen);
    bit_in_sview = (i == SIE_B) || (i == SPIE_B) || (i == SPP_B) ||
                   (i == VS_LO) || (i == VS_LO + 1) ||
                   (i == FS_LO) || (i == FS_LO + 1) ||
                   (i == XS_LO) || (i == XS_LO + 1) ||
                   (i == SUM_B) || (i == MXR_B) ||
                   ((xlen >= 64) && ((i == UXL_LO) || (i == UXL_LO + 1)));
  endfunction

endpackage

// File: rtl/mstatus_wmask.sv
module mstatus_wmask #(
  parameter int unsigned XLEN = 64
) (
  input  logic [XLEN-1:0] raw_i,
  output logic [XLEN-1:0] kept_o
);
  import mstatus_pkg::*;

  for (genvar i = 0; i < XLEN; i++) begin : g_bit
    if (bit_from_write(i)) begin : g_take
      assign kept_o[i] = raw_i[i];
    end else begin : g_zero
      assign kept_o[i] = 1'b0;
    end
  end

endmodule

// File: rtl/mstatus_fixup.sv
module mstatus_fixup #(
  parameter int unsigned XLEN = 64
) (
  input  logic [XLEN-1:0] kept_i,
  input  logic [XLEN-1:0] old_i,
  input  logic            user_en_i,
  input  logic            super_en_i,
  input  logic            fp_in_int_i,
  output logic [XLEN-1:0] next_o
);
  import mstatus_pkg::*;

  logic [XLEN-1:0] core;
  logic [XLEN-1:0] with_xl;
  logic [1:0]      fs_v, xs_v, vs_v;
  logic            dirty;

  always_comb begin
    core = kept_i;
    if (!prv_ok(kept_i[MPP_LO +: 2], user_en_i, super_en_i))
      core[MPP_LO +: 2] = prv_lowest(user_en_i, super_en_i);
    core[XS_LO +: 2] = EXT_OFF;
    if (fp_in_int_i)
      core[FS_LO +: 2] = EXT_OFF;
    if (!user_en_i)
      core[MPRV_B] = 1'b0;
  end

  if (XLEN >= 64) begin : g_xl
    always_comb begin
      with_xl = core;
      with_xl[UXL_LO +: 2] = old_i[UXL_LO +: 2];
      with_xl[SXL_LO +: 2] = old_i[SXL_LO +: 2];
      with_xl[37:36]       = 2'b00;
    end
  end else begin : g_no_xl
    assign with_xl = core;
  end

  assign fs_v  = with_xl[FS_LO +: 2];
  assign xs_v  = with_xl[XS_LO +: 2];
  assign vs_v  = with_xl[VS_LO +: 2];
  assign dirty = (fs_v == EXT_DIRTY) || (xs_v == EXT_DIRTY) || (vs_v == EXT_DIRTY);

  assign next_o = {dirty, with_xl[XLEN-2:0]};

endmodule

// File: rtl/mstatus_sview.sv
module mstatus_sview #(
  parameter int unsigned XLEN = 64
) (
  input  logic [XLEN-1:0] full_i,
  output logic [XLEN-1:0] view_o
);
  import mstatus_pkg::*;

  for (genvar i = 0; i < XLEN - 1; i++) begin : g_bit
    if (bit_in_sview(i, XLEN)) begin : g_show
      assign view_o[i] = full_i[i];
    end else begin : g_hide
      assign view_o[i] = 1'b0;
    end
  end
  assign view_o[XLEN-1] = full_i[XLEN-1];

endmodule

// File: rtl/mstatus_legal.sv
module mstatus_legal #(
  parameter int unsigned XLEN     = 64,
  parameter logic [1:0]  RESET_XL = 2'b10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [XLEN-1:0] wr_data,
  input  logic            cfg_user_en,
  input  logic            cfg_super_en,
  input  logic            cfg_fp_in_int,
  output logic [XLEN-1:0] status_o,
  output logic [XLEN-1:0] sstatus_o
);
  import mstatus_pkg::*;

  logic [XLEN-1:0] kept;
  logic [XLEN-1:0] next_val;
  logic [XLEN-1:0] rst_val;
  logic [XLEN-1:0] stat_q;

  always_comb begin
    rst_val = '0;
    rst_val[MPP_LO +: 2] = PRV_M;
  end

  logic [XLEN-1:0] rst_full;
  if (XLEN >= 64) begin : g_rst_xl
    always_comb begin
      rst_full = rst_val;
      rst_full[UXL_LO +: 2] = RESET_XL;
      rst_full[SXL_LO +: 2] = RESET_XL;
    end
  end else begin : g_rst_plain
    assign rst_full = rst_val;
  end

  mstatus_wmask #(.XLEN(XLEN)) u_wmask (
    .raw_i  (wr_data),
    .kept_o (kept)
  );

  mstatus_fixup #(.XLEN(XLEN)) u_fixup (
    .kept_i      (kept),
    .old_i       (stat_q),
    .user_en_i   (cfg_user_en),
    .super_en_i  (cfg_super_en),
    .fp_in_int_i (cfg_fp_in_int),
    .next_o      (next_val)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     stat_q <= rst_full;
    else if (wr_en) stat_q <= next_val;
  end

  assign status_o = stat_q;

  mstatus_sview #(.XLEN(XLEN)) u_sview (
    .full_i (stat_q),
    .view_o (sstatus_o)
  );

endmodule

// File: rtl/mstatus_legal_chk.sv
module mstatus_legal_chk #(
  parameter int unsigned XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic            cfg_user_en,
  input logic            cfg_fp_in_int,
  input logic [XLEN-1:0] status_o,
  input logic [XLEN-1:0] sstatus_o
);

  a_r2_gap_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (status_o[6] == 1'b0 && status_o[2] == 1'b0));

  a_r3_no_reserved_mpp: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (status_o[12:11] != 2'b10));

  a_r4_xs_off: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (status_o[16:15] == 2'b00));

  a_r5_fs_forced: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cfg_fp_in_int) |=> (status_o[14:13] == 2'b00));

  a_r6_sd_summary: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[XLEN-1] == ((status_o[14:13] == 2'b11) || (status_o[16:15] == 2'b11) ||
                         (status_o[10:9] == 2'b11)));

  a_r7_mprv_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !cfg_user_en) |=> (status_o[17] == 1'b0));

  a_r9_view_top: assert property (@(posedge clk) disable iff (!rst_n)
    (sstatus_o[XLEN-1] == status_o[XLEN-1]) && (sstatus_o[12:11] == 2'b00) &&
    (sstatus_o[17] == 1'b0) && (sstatus_o[19:18] == status_o[19:18]));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(status_o));

  if (XLEN >= 64) begin : g_xl
    a_r8_xl_fixed: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ($stable(status_o[35:32]) && status_o[37:36] == 2'b00));
  end

endmodule

bind mstatus_legal mstatus_legal_chk #(.XLEN(XLEN)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .wr_en         (wr_en),
  .cfg_user_en   (cfg_user_en),
  .cfg_fp_in_int (cfg_fp_in_int),
  .status_o      (status_o),
  .sstatus_o     (sstatus_o)
);

// File: tb/mstatus_legal_tb.sv
module mstatus_legal_tb_top;
  localparam int unsigned XLEN   = 64;
  localparam time         CLK_PERIOD = 10ns;
  localparam logic [63:0] KEEP_M = 64'h0000_0000_007F_FFBB;
  localparam logic [63:0] SVIEW_M = 64'h8000_0003_000D_E722;
  localparam logic [63:0] RST_EXP = 64'h0000_000A_0000_1800;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            wr_en = 1'b0;
  logic [XLEN-1:0] wr_data = '0;
  logic            u_en = 1'b1, s_en = 1'b1, fpi = 1'b0;
  logic [XLEN-1:0] status_o, sstatus_o;

  int unsigned total = 0, bad = 0;
  logic [63:0] model_q;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mstatus_legal #(.XLEN(XLEN)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .cfg_user_en(u_en), .cfg_super_en(s_en), .cfg_fp_in_int(fpi),
    .status_o(status_o), .sstatus_o(sstatus_o)
  );

  function automatic logic [63:0] model_next(logic [63:0] old, logic [63:0] w,
                                             logic u, logic s, logic f);
    logic [63:0] n;
    logic ok;
    n = w & KEEP_M;
    case (n[12:11])
      2'b11: ok = 1'b1;
      2'b01: ok = s;
      2'b00: ok = u;
      default: ok = 1'b0;
    endcase
    if (!ok) n[12:11] = u ? 2'b00 : (s ? 2'b01 : 2'b11);
    n[16:15] = 2'b00;
    if (f) n[14:13] = 2'b00;
    if (!u) n[17] = 1'b0;
    n[35:32] = old[35:32];
    n[37:36] = 2'b00;
    n[63] = (n[14:13] == 2'b11) || (n[16:15] == 2'b11) || (n[10:9] == 2'b11);
    return n;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic do_write(logic [63:0] w, logic u, logic s, logic f, string req);
    @(negedge clk);
    wr_en = 1'b1; wr_data = w; u_en = u; s_en = s; fpi = f;
    model_q = model_next(model_q, w, u, s, f);
    @(posedge clk); #1;
    wr_en = 1'b0;
    check(req, status_o, model_q);
    check("R9", sstatus_o, model_q & SVIEW_M);
  endtask

  task automatic idle_check();
    @(negedge clk);
    wr_en = 1'b0; wr_data = {$urandom, $urandom};
    @(posedge clk); #1;
    check("R10", status_o, model_q);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    total++; bad++;
    $display("FAIL watchdog act=hang exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #1;
    check("R1", status_o, RST_EXP);
    check("R9", sstatus_o, RST_EXP & SVIEW_M);
    @(negedge clk) rst_n = 1'b1;
    model_q = RST_EXP;

    // R2 all ones, every strap setting for R3 reserved MPP
    do_write('1, 1, 1, 0, "R2");
    for (int c = 0; c < 8; c++) begin
      do_write(64'h0000_0000_0000_1000, c[0], c[1], c[2], "R3");
    end
    do_write(64'h0000_0000_0000_0000, 0, 1, 0, "R3");
    do_write(64'h0000_0000_0000_0800, 0, 0, 0, "R3");
    // R4 XS written dirty
    do_write(64'h0000_0000_0001_8000, 1, 1, 0, "R4");
    // R5 FS dirty with and without forcing, R6 SD follows
    do_write(64'h0000_0000_0000_6000, 1, 1, 1, "R5");
    do_write(64'h0000_0000_0000_6000, 1, 1, 0, "R6");
    do_write(64'h0000_0000_0000_0600, 1, 1, 1, "R6");
    do_write(64'h0000_0000_0000_0400, 1, 1, 0, "R6");
    // R7 MPRV
    do_write(64'h0000_0000_0002_0000, 0, 1, 0, "R7");
    do_write(64'h0000_0000_0002_0000, 1, 1, 0, "R7");
    // R8 try to rewrite XLEN fields and 37:36
    do_write(64'h0000_003F_0000_0000, 1, 1, 0, "R8");
    check("R8", {60'd0, status_o[35:32]}, 64'h0000_0000_0000_000A);
    idle_check();
    idle_check();

    for (int k = 0; k < 400; k++) begin
      logic [63:0] w;
      w = {$urandom, $urandom};
      do_write(w, 1'($urandom), 1'($urandom), 1'($urandom), "R2");
      if (($urandom & 3) == 0) idle_check();
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule